// File: doc/BRIEF.md
# Interleaved Multi-Bank Byte Memory

This block is a byte-wide memory made of NB = 2^BANK_BITS independent storage banks. Every bank answers a read after a fixed number of cycles, LAT. Each address is split into a bank number and an offset inside that bank. The parameter `LOW_ORDER` selects the split. When it is 1 (interleaved), the least significant bits choose the bank, so neighbouring bytes sit in different banks. When it is 0 (banked), the most significant bits choose the bank.

Requests enter through a valid/ready handshake. The block serves single-byte writes, single-byte reads, and whole-line reads of NB consecutive bytes. In interleaved mode a line read sends one read to each bank on back-to-back cycles and never waits for an earlier return. The line is therefore complete after about one bank latency plus one cycle per byte. In banked mode all bytes of a line live in one bank, so the reads are strictly serialized.

The block holds one request at a time. `req_ready` is low from acceptance until the response has been delivered. The response outputs carry a one-cycle pulse and accept no back-pressure: the consumer must capture the result in the cycle it is flagged. Only bits 8·i+7..8·i of a line depend on the byte at base+i.

Top module: `ilv_mem`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `req_ready` is 1 and both `rd_valid` and `line_valid` are 0.
- R2: An accepted request with `req_line`=0 and `req_we`=1 stores `req_wdata` at `req_addr`. `req_ready` is 0 for exactly the one cycle after the accepting edge. A read accepted right afterwards returns the new byte.
- R3: An accepted request with `req_line`=0 and `req_we`=0 returns the stored byte on `rd_data` with a one-cycle `rd_valid` pulse. The pulse is visible LAT+1 clock edges after the accepting edge.
- R4: A line request returns, in byte lane i of `line_data` (bits 8·i+7..8·i), the byte stored at base+i. Here base is `req_addr` with its low BANK_BITS bits forced to zero, so those bits are ignored.
- R5: With `LOW_ORDER`=1, the bank is `addr[BANK_BITS-1:0]` and the offset is the remaining upper bits. A line read issues one read to each of banks 0, 1, … NB-1 on consecutive cycles. `line_valid` pulses for one cycle LAT+NB edges after acceptance.
- R6: With `LOW_ORDER`=0, the bank is the top BANK_BITS address bits and the offset is the lower bits. Line reads are serialized: each read is issued in the cycle its predecessor's byte is collected, never in two adjacent cycles. `line_valid` pulses NB·(LAT+1) edges after acceptance.
- R7: `req_ready` stays 0 from the cycle after acceptance until the response pulse. It returns to 1 in the cycle after that pulse. A request presented while `req_ready` is 0 is ignored and writes nothing.
- R8: When `req_line`=1, `req_we` and `req_wdata` are ignored and memory is unchanged.
- R9: `rd_valid` and `line_valid` are never high together. A single read never raises `line_valid`, and a line read never raises `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_we | input | 1 | 1 = write byte, 0 = read (single requests only) |
| req_line | input | 1 | 1 = read a whole aligned line of NB bytes |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 8 | Write byte |
| rd_valid | output | 1 | One-cycle pulse: single-read byte on `rd_data` |
| rd_data | output | 8 | Single-read result |
| line_valid | output | 1 | One-cycle pulse: complete line on `line_data` |
| line_data | output | 8·NB | Line result, lowest address in the least significant byte |

## Verification
The assertions assume a request is held for only one cycle, in a cycle where `req_ready` is high, with known values on every request field. They also assume a line is collected only after all of its reads return in issue order. The bench drives `req_valid` for exactly one cycle at a time, on a negative edge, after seeing `req_ready` high. The only exception is the deliberate busy-time poke, which tests that such requests are ignored. Before any random read, every address is written, so no read ever returns an undefined byte. Interleaved and banked instances receive identical stimulus and share one reference image.

// File: rtl/ilv_mem_pkg.sv
package ilv_mem_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_LINE  = 2'd3
  } op_e;

  // Cycles from the accepting edge to the line pulse.
  function automatic int unsigned line_cycles(input int unsigned lat,
                                              input int unsigned nb,
                                              input bit low);
    return low ? (lat + nb) : (nb * (lat + 1));
  endfunction

endpackage

// File: rtl/ilv_mem_bank.sv
module ilv_mem_bank #(
  parameter int OFF_W = 9,
  parameter int LAT   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic             wr_en,
  input  logic [OFF_W-1:0] off,
  input  logic [7:0]       wdata,
  output logic             rvalid,
  output logic [7:0]       rdata
);
  localparam int DEPTH = 1 << OFF_W;

  logic [7:0]     cells [DEPTH];
  logic [LAT-1:0] vpipe;
  logic [7:0]     dpipe [LAT];

  always_ff @(posedge clk) begin
    if (wr_en) cells[off] <= wdata;
  end

  // Data path carries no reset; only the valid chain does.
  always_ff @(posedge clk) begin
    dpipe[0] <= cells[off];
    for (int i = 1; i < LAT; i++) dpipe[i] <= dpipe[i-1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vpipe <= '0;
    end else begin
      vpipe[0] <= rd_en;
      for (int i = 1; i < LAT; i++) vpipe[i] <= vpipe[i-1];
    end
  end

  assign rvalid = vpipe[LAT-1];
  assign rdata  = dpipe[LAT-1];

  AST_RW_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && wr_en)); // R2

endmodule

// File: rtl/ilv_mem_issue.sv
module ilv_mem_issue
  import ilv_mem_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int BANK_BITS = 3,
  parameter bit LOW_ORDER = 1'b1,
  localparam int OFF_W    = ADDR_W - BANK_BITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_we,
  input  logic                 req_line,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [7:0]           req_wdata,
  input  logic                 got,
  input  logic                 done,
  output logic                 req_ready,
  output logic                 accept,
  output logic                 line_mode,
  output logic                 bank_rd,
  output logic                 bank_wr,
  output logic [BANK_BITS-1:0] bank_sel,
  output logic [OFF_W-1:0]     bank_off,
  output logic [7:0]           bank_wdata
);
  op_e               state;
  logic [ADDR_W-1:0] mar;
  logic [7:0]        mbr;
  logic [BANK_BITS:0] cnt;
  logic              pend;
  logic              slot_free;
  logic [ADDR_W-1:0] cur_addr;

  assign req_ready  = (state == OP_IDLE);
  assign accept     = req_valid && req_ready;
  assign line_mode  = (state == OP_LINE);
  assign bank_wr    = (state == OP_WRITE);
  assign bank_wdata = mbr;

  // Line reads walk the low bits of the aligned base.
  assign cur_addr = line_mode ? {mar[ADDR_W-1:BANK_BITS], cnt[BANK_BITS-1:0]} : mar;

  generate
    if (LOW_ORDER) begin : g_lo_map
      assign bank_sel = cur_addr[BANK_BITS-1:0];
      assign bank_off = cur_addr[ADDR_W-1:BANK_BITS];
    end else begin : g_hi_map
      assign bank_sel = cur_addr[ADDR_W-1 -: BANK_BITS];
      assign bank_off = cur_addr[OFF_W-1:0];
    end
  endgenerate

  // Interleaved: a new bank every cycle. Banked: wait for the previous return.
  assign slot_free = LOW_ORDER ? 1'b1 : (!pend || got);

  always_comb begin
    case (state)
      OP_READ: bank_rd = (cnt == '0);
      OP_LINE: bank_rd = !cnt[BANK_BITS] && slot_free;
      default: bank_rd = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= OP_IDLE;
      mar   <= '0;
      mbr   <= '0;
      cnt   <= '0;
      pend  <= 1'b0;
    end else begin
      if (bank_rd)  pend <= 1'b1;
      else if (got) pend <= 1'b0;
      if (bank_rd) cnt <= cnt + 1'b1;
      case (state)
        OP_IDLE: begin
          if (req_valid) begin
            mar   <= req_addr;
            mbr   <= req_wdata;
            cnt   <= '0;
            state <= req_line ? OP_LINE : (req_we ? OP_WRITE : OP_READ);
          end
        end
        OP_WRITE: state <= OP_IDLE;
        default:  if (done) state <= OP_IDLE;
      endcase
    end
  end

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready); // R7

  generate
    if (LOW_ORDER) begin : g_lo_chk
      AST_LO_BANK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_rd && line_mode && $past(bank_rd && line_mode))
          |-> (bank_sel == $past(bank_sel) + 1'b1)); // R5
    end else begin : g_hi_chk
      AST_HO_NO_BACK2BACK: assert property (@(posedge clk) disable iff (!rst_n)
        bank_rd |=> !bank_rd); // R6
    end
  endgenerate

endmodule

// File: rtl/ilv_mem_gather.sv
module ilv_mem_gather #(
  parameter int NB      = 8,
  localparam int LINE_W = 8 * NB,
  localparam int IDX_W  = $clog2(NB)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              line_mode,
  input  logic [NB-1:0]     bvld,
  input  logic [NB*8-1:0]   bdat,
  output logic              got,
  output logic              rd_valid,
  output logic [7:0]        rd_data,
  output logic              line_valid,
  output logic [LINE_W-1:0] line_data
);
  logic [7:0]       merged;
  logic             any_ret;
  logic [IDX_W-1:0] idx;

  // Returns arrive in issue order, at most one per cycle.
  always_comb begin
    merged = '0;
    for (int b = 0; b < NB; b++) begin
      if (bvld[b]) merged = merged | bdat[b*8 +: 8];
    end
  end
  assign any_ret = |bvld;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      got        <= 1'b0;
      rd_valid   <= 1'b0;
      rd_data    <= '0;
      line_valid <= 1'b0;
      line_data  <= '0;
      idx        <= '0;
    end else begin
      got        <= any_ret;
      rd_valid   <= 1'b0;
      line_valid <= 1'b0;
      if (accept) begin
        idx <= '0;
      end else if (any_ret) begin
        if (line_mode) begin
          line_data[idx*8 +: 8] <= merged;
          idx <= idx + 1'b1;
          if (idx == IDX_W'(NB - 1)) line_valid <= 1'b1;
        end else begin
          rd_data  <= merged;
          rd_valid <= 1'b1;
        end
      end
    end
  end

  AST_ONE_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bvld)); // R9
  AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid); // R3
  AST_LINE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    line_valid |=> !line_valid); // R5

endmodule

// File: rtl/ilv_mem.sv
module ilv_mem
  import ilv_mem_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int BANK_BITS = 3,
  parameter int LAT       = 8,
  parameter bit LOW_ORDER = 1'b1,
  localparam int NB       = 1 << BANK_BITS,
  localparam int LINE_W   = 8 * NB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic              req_line,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_wdata,
  output logic              rd_valid,
  output logic [7:0]        rd_data,
  output logic              line_valid,
  output logic [LINE_W-1:0] line_data
);
  localparam int OFF_W    = ADDR_W - BANK_BITS;
  localparam int LINE_CYC = line_cycles(LAT, NB, LOW_ORDER);

  logic                 accept, line_mode, got, done;
  logic                 bank_rd, bank_wr;
  logic [BANK_BITS-1:0] bank_sel;
  logic [OFF_W-1:0]     bank_off;
  logic [7:0]           bank_wdata;
  logic [NB-1:0]        bvld;
  logic [NB*8-1:0]      bdat;

  assign done = rd_valid || line_valid;

  ilv_mem_issue #(
    .ADDR_W(ADDR_W), .BANK_BITS(BANK_BITS), .LOW_ORDER(LOW_ORDER)
  ) u_issue (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_we(req_we), .req_line(req_line),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .got(got), .done(done),
    .req_ready(req_ready), .accept(accept), .line_mode(line_mode),
    .bank_rd(bank_rd), .bank_wr(bank_wr), .bank_sel(bank_sel),
    .bank_off(bank_off), .bank_wdata(bank_wdata)
  );

  for (genvar b = 0; b < NB; b++) begin : g_bank
    ilv_mem_bank #(.OFF_W(OFF_W), .LAT(LAT)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .rd_en(bank_rd && (bank_sel == BANK_BITS'(b))),
      .wr_en(bank_wr && (bank_sel == BANK_BITS'(b))),
      .off(bank_off), .wdata(bank_wdata),
      .rvalid(bvld[b]), .rdata(bdat[b*8 +: 8])
    );
  end

  ilv_mem_gather #(.NB(NB)) u_gather (
    .clk(clk), .rst_n(rst_n),
    .accept(accept), .line_mode(line_mode),
    .bvld(bvld), .bdat(bdat),
    .got(got), .rd_valid(rd_valid), .rd_data(rd_data),
    .line_valid(line_valid), .line_data(line_data)
  );

  // Cycle count since acceptance, used only by the timing checks below.
  logic [15:0] since;
  always_ff @(posedge clk) begin
    if (!rst_n)              since <= '0;
    else if (accept)         since <= '0;
    else if (since != '1)    since <= since + 1'b1;
  end

  AST_RD_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (since == 16'(LAT + 1))); // R3
  AST_LINE_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    line_valid |-> (since == 16'(LINE_CYC))); // R5
  AST_RESP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && line_valid)); // R9
  AST_READY_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> req_ready); // R7

endmodule

// File: tb/ilv_mem_test.sv
`timescale 1ns/1ps
module ilv_mem_test;
  localparam int AW  = 12;
  localparam int NB  = 8;
  localparam int LAT = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        rv [2];
  logic        rwe [2];
  logic        rln [2];
  logic [AW-1:0] ra [2];
  logic [7:0]  rwd [2];
  logic        rdy [2];
  logic        vv [2];
  logic        lv [2];
  logic [7:0]  rdat [2];
  logic [63:0] ldat [2];

  logic [7:0] shadow [1 << AW];
  int n_chk = 0;
  int n_bad = 0;

  ilv_mem #(.ADDR_W(AW), .BANK_BITS(3), .LAT(LAT), .LOW_ORDER(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(rv[0]), .req_ready(rdy[0]),
    .req_we(rwe[0]), .req_line(rln[0]), .req_addr(ra[0]), .req_wdata(rwd[0]),
    .rd_valid(vv[0]), .rd_data(rdat[0]), .line_valid(lv[0]), .line_data(ldat[0]));

  ilv_mem #(.ADDR_W(AW), .BANK_BITS(3), .LAT(LAT), .LOW_ORDER(1'b0)) uut_hi (
    .clk(clk), .rst_n(rst_n), .req_valid(rv[1]), .req_ready(rdy[1]),
    .req_we(rwe[1]), .req_line(rln[1]), .req_addr(ra[1]), .req_wdata(rwd[1]),
    .rd_valid(vv[1]), .rd_data(rdat[1]), .line_valid(lv[1]), .line_data(ldat[1]));

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_line(input logic [AW-1:0] a);
    logic [63:0] v;
    for (int i = 0; i < NB; i++) v[i*8 +: 8] = shadow[{a[AW-1:3], 3'(i)}];
    return v;
  endfunction

  task automatic do_op(input int m, input bit we, input bit ln, input logic [AW-1:0] a,
                       input logic [7:0] d, input bit poke, input logic [AW-1:0] pa);
    int k;
    int want;
    bit seen;
    bit stray;
    string ttag;
    @(negedge clk);
    check(rdy[m] === 1'b1, "R7", 64'(rdy[m]), 64'd1);
    rv[m] = 1'b1; rwe[m] = we; rln[m] = ln; ra[m] = a; rwd[m] = d;
    @(negedge clk);
    rv[m] = 1'b0;
    if (we && !ln) begin
      check(rdy[m] === 1'b0, "R2", 64'(rdy[m]), 64'd0);
      @(negedge clk);
      check(rdy[m] === 1'b1, "R2", 64'(rdy[m]), 64'd1);
      return;
    end
    check(rdy[m] === 1'b0, "R7", 64'(rdy[m]), 64'd0);
    k = 0; seen = 1'b0; stray = 1'b0;
    while (!seen && k < 500) begin
      if (poke && k == 1) begin
        rv[m] = 1'b1; rwe[m] = 1'b1; rln[m] = 1'b0; ra[m] = pa; rwd[m] = ~shadow[pa];
      end else begin
        rv[m] = 1'b0;
      end
      @(negedge clk);
      k++;
      if (ln ? lv[m] : vv[m]) seen = 1'b1;
      if (ln ? vv[m] : lv[m]) stray = 1'b1;
      if (!seen) check(rdy[m] === 1'b0, "R7", 64'(rdy[m]), 64'd0);
    end
    rv[m] = 1'b0;
    want = !ln ? (LAT + 1) : ((m == 0) ? (LAT + NB) : (NB * (LAT + 1)));
    ttag = !ln ? "R3" : ((m == 0) ? "R5" : "R6");
    check(k == want, ttag, 64'(k), 64'(want));
    if (ln) check(ldat[m] === exp_line(a), "R4", ldat[m], exp_line(a));
    else    check(rdat[m] === shadow[a], "R3", 64'(rdat[m]), 64'(shadow[a]));
    check(!stray, "R9", 64'(stray), 64'd0);
    @(negedge clk);
    check(rdy[m] === 1'b1 && !vv[m] && !lv[m], "R7",
          {61'd0, rdy[m], vv[m], lv[m]}, 64'b100);
  endtask

  task automatic both(input bit we, input bit ln, input logic [AW-1:0] a,
                      input logic [7:0] d, input bit poke, input logic [AW-1:0] pa);
    do_op(0, we, ln, a, d, poke, pa);
    do_op(1, we, ln, a, d, poke, pa);
    if (we && !ln) shadow[a] = d;
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #1800000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd91));
    for (int m = 0; m < 2; m++) begin
      rv[m] = 0; rwe[m] = 0; rln[m] = 0; ra[m] = '0; rwd[m] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: state during reset
    for (int m = 0; m < 2; m++)
      check(rdy[m] === 1'b1 && vv[m] === 1'b0 && lv[m] === 1'b0, "R1",
            {61'd0, rdy[m], vv[m], lv[m]}, 64'b100);
    rst_n = 1'b1;
    @(negedge clk);
    for (int m = 0; m < 2; m++)
      check(rdy[m] === 1'b1 && vv[m] === 1'b0 && lv[m] === 1'b0, "R1",
            {61'd0, rdy[m], vv[m], lv[m]}, 64'b100);

    // R2: fill the whole space with a known image
    for (int a = 0; a < (1 << AW); a++)
      both(1'b1, 1'b0, AW'(a), 8'(a * 37 + (a >> 5)), 1'b0, '0);

    // R3: single reads at the ends of the space
    both(1'b0, 1'b0, '0, '0, 1'b0, '0);
    both(1'b0, 1'b0, '1, '0, 1'b0, '0);
    // R2: write followed at once by a read of the same byte
    both(1'b1, 1'b0, 12'h2A5, 8'h5C, 1'b0, '0);
    both(1'b0, 1'b0, 12'h2A5, '0, 1'b0, '0);
    // R4/R5/R6: aligned line, misaligned base, last line of memory
    both(1'b0, 1'b1, 12'h000, '0, 1'b0, '0);
    both(1'b0, 1'b1, 12'h00D, '0, 1'b0, '0);
    both(1'b0, 1'b1, 12'hFFD, '0, 1'b0, '0);
    // R8: write flag on a line request leaves memory untouched
    both(1'b1, 1'b1, 12'h130, 8'hEE, 1'b0, '0);
    both(1'b0, 1'b0, 12'h130, '0, 1'b0, '0);
    both(1'b0, 1'b1, 12'h137, '0, 1'b0, '0);
    // R7: write attempts while busy are ignored
    both(1'b0, 1'b1, 12'h400, '0, 1'b1, 12'h064);
    both(1'b0, 1'b0, 12'h064, '0, 1'b0, '0);
    both(1'b0, 1'b0, 12'h800, '0, 1'b1, 12'h801);
    both(1'b0, 1'b0, 12'h801, '0, 1'b0, '0);

    // Random mix of writes, reads and lines
    for (int i = 0; i < 150; i++) begin
      int kind;
      logic [AW-1:0] a;
      logic [7:0] d;
      kind = $urandom_range(0, 3);
      a = AW'($urandom_range(0, (1 << AW) - 1));
      d = 8'($urandom_range(0, 255));
      case (kind)
        0: both(1'b1, 1'b0, a, d, 1'b0, '0);
        1: both(1'b0, 1'b0, a, d, 1'b0, '0);
        2: both(1'b0, 1'b1, a, d, 1'b0, '0);
        default: both(1'b1, 1'b1, a, d, 1'b1, AW'(a ^ 12'h155));
      endcase
    end

    summary();
    $finish;
  end

endmodule